// File: doc/BRIEF.md
# ADC Sample FIFO with DMA Request

This block buffers conversion results between an ADC sequencer and the system side. Each completed conversion offers a 12-bit result and an error bit on the write port. When the FIFO is enabled, the block formats the sample into a 16-bit word and stores it. Two format options apply before storage. One places the sample's error bit in bit 15. The other narrows the result to its upper 8 bits, so a byte-wide DMA transfer can move it.

The read side is show-ahead: `data_o` always carries the oldest stored word, and a pop removes it. When the FIFO is full, new samples are dropped and never backpressured. One programmable threshold drives both the DMA request and the interrupt, and each of the two has its own enable. Two sticky flags record dropped samples and pops on an empty FIFO. Writing one to a flag's clear input clears it.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty (`empty_o`=1, `level_o`=0, `data_o`=0), and `dreq_o`, `irq_o`, `ovf_o` and `unf_o` are all 0.
- R2: A push with the FIFO enabled stores one word. Words leave in arrival order. `data_o` shows the oldest word, `level_o` counts the stored words, and `empty_o` is 1 exactly when `level_o` is 0.
- R3: A push that finds the FIFO holding DEPTH (4) words, with no pop in the same cycle, is discarded. The level and contents stay unchanged, and `ovf_o` is 1 from the next cycle.
- R4: While `fifo_en_i` is 0, pushes store nothing and leave the level unchanged.
- R5: `dreq_o` is 1 exactly when `dreq_en_i`=1 and `level_o` >= `thresh_i`. `irq_o` is 1 exactly when `irq_en_i`=1 and `level_o` >= `thresh_i`. Both follow the level in the same cycle.
- R6: With `err_mode_i`=1, bit 15 of the stored word equals the sample's `res_err_i`. With `err_mode_i`=0, bit 15 is 0.
- R7: With `shift_mode_i`=0, the word holds `res_i` in bits 11:0. With `shift_mode_i`=1, it holds `res_i[11:4]` in bits 7:0. All bits below 15 that carry no result bits are 0. The format is fixed when the sample is pushed.
- R8: A pop while empty changes nothing else, `data_o` reads 0 while empty, and `unf_o` is 1 from the next cycle.
- R9: A push and a pop in the same cycle on a full FIFO remove the oldest word, accept the new one, and keep the level at DEPTH.
- R10: `ovf_clr_i`=1 clears `ovf_o` and `unf_clr_i`=1 clears `unf_o` on the next cycle. A new setting event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Allow results to be written into the FIFO |
| err_mode_i | input | 1 | Place the error flag in bit 15 |
| shift_mode_i | input | 1 | Store the upper 8 result bits only |
| thresh_i | input | LVL_W (3) | Request threshold level |
| dreq_en_i | input | 1 | DMA request enable |
| irq_en_i | input | 1 | Interrupt enable |
| push_i | input | 1 | Conversion complete strobe |
| res_i | input | RES_W (12) | Conversion result |
| res_err_i | input | 1 | Conversion error flag |
| pop_i | input | 1 | Remove the oldest word |
| ovf_clr_i | input | 1 | Clear overflow flag (write one) |
| unf_clr_i | input | 1 | Clear underflow flag (write one) |
| data_o | output | 16 | Oldest word, 0 when empty |
| empty_o | output | 1 | FIFO empty |
| level_o | output | LVL_W (3) | Stored word count |
| dreq_o | output | 1 | DMA request |
| irq_o | output | 1 | Interrupt |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its defaults: DEPTH 4 and a 12-bit result, which gives a 3-bit level. At that depth, every threshold from 0 to 4 fits in a few cycles, including 0, where the request is always on, and 4, where only a full FIFO raises it. The full-FIFO paths are also short: a dropped sample, a simultaneous push and pop, and a set-versus-clear collision on the sticky flags each take only a handful of pushes. Both format options are applied alone and together, and a mode change is checked against words that were already stored.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int WORD_W  = 16;
  localparam int ERR_BIT = 15;
  localparam int BYTE_W  = 8;
endpackage

// File: rtl/afifo_fmt.sv
module afifo_fmt
  import adc_fifo_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              err_i,
  input  logic              err_mode_i,
  input  logic              shift_mode_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SHIFT = RES_W - BYTE_W;

  always_comb begin
    word_o = '0;
    if (shift_mode_i) word_o[BYTE_W-1:0] = res_i[RES_W-1:SHIFT];
    else              word_o[RES_W-1:0]  = res_i;
    word_o[ERR_BIT] = err_mode_i & err_i;
  end
endmodule

// File: rtl/afifo_store.sv
module afifo_store
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              rd_req_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              drop_o,
  output logic              under_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  cnt_q;
  logic              full, empty, do_rd, do_wr;

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_rd   = rd_req_i & ~empty;
  assign do_wr   = wr_req_i & (~full | do_rd);
  assign drop_o  = wr_req_i & full & ~rd_req_i;
  assign under_o = rd_req_i & empty;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (do_wr && wr_ptr_q == PTR_W'(i)) mem_q[i] <= wr_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= inc(wr_ptr_q);
      if (do_rd) rd_ptr_q <= inc(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_word_o = empty ? '0 : mem_q[rd_ptr_q];
  assign level_o   = cnt_q;
endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             dreq_en_i,
  input  logic             irq_en_i,
  input  logic             drop_i,
  input  logic             under_i,
  input  logic             ovf_clr_i,
  input  logic             unf_clr_i,
  output logic             dreq_o,
  output logic             irq_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic at_thresh;
  assign at_thresh = (level_i >= thresh_i);
  assign dreq_o    = dreq_en_i & at_thresh;
  assign irq_o     = irq_en_i & at_thresh;

  // set has priority over write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (drop_i)         ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
      if (under_i)        unf_o <= 1'b1;
      else if (unf_clr_i) unf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RES_W = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              err_mode_i,
  input  logic              shift_mode_i,
  input  logic [LVL_W-1:0]  thresh_i,
  input  logic              dreq_en_i,
  input  logic              irq_en_i,
  input  logic              push_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              res_err_i,
  input  logic              pop_i,
  input  logic              ovf_clr_i,
  input  logic              unf_clr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              dreq_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [WORD_W-1:0] fmt_word;
  logic              drop, under;

  afifo_fmt #(.RES_W(RES_W)) u_fmt (
    .res_i        (res_i),
    .err_i        (res_err_i),
    .err_mode_i   (err_mode_i),
    .shift_mode_i (shift_mode_i),
    .word_o       (fmt_word)
  );

  afifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (push_i & fifo_en_i),
    .wr_word_i (fmt_word),
    .rd_req_i  (pop_i),
    .rd_word_o (data_o),
    .level_o   (level_o),
    .drop_o    (drop),
    .under_o   (under)
  );

  afifo_flags #(.LVL_W(LVL_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_o),
    .thresh_i  (thresh_i),
    .dreq_en_i (dreq_en_i),
    .irq_en_i  (irq_en_i),
    .drop_i    (drop),
    .under_i   (under),
    .ovf_clr_i (ovf_clr_i),
    .unf_clr_i (unf_clr_i),
    .dreq_o    (dreq_o),
    .irq_o     (irq_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  assign empty_o = (level_o == '0);
endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [LVL_W-1:0] thresh_i,
  input logic [15:0]      data_o,
  input logic             empty_o,
  input logic [LVL_W-1:0] level_o,
  input logic             dreq_o,
  input logic             irq_o,
  input logic             ovf_o,
  input logic             unf_o
);
  logic full;
  assign full = (level_o == LVL_W'(DEPTH));

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && fifo_en_i && !pop_i) |=> (full && ovf_o));

  assert_disabled_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !pop_i) |=> (level_o == $past(level_o)));

  assert_req_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_o || irq_o) |-> (level_o >= thresh_i));

  assert_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i) |=> unf_o);

  assert_empty_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (data_o == '0));

  assert_full_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && fifo_en_i && pop_i) |=> full);
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .thresh_i  (thresh_i),
  .data_o    (data_o),
  .empty_o   (empty_o),
  .level_o   (level_o),
  .dreq_o    (dreq_o),
  .irq_o     (irq_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/tb_adc_sample_fifo.sv
module tb_adc_sample_fifo;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fifo_en = 0, err_mode = 0, shift_mode = 0;
  logic [2:0]  thresh = 3'd1;
  logic        dreq_en = 0, irq_en = 0;
  logic        push = 0, res_err = 0, pop = 0, ovf_clr = 0, unf_clr = 0;
  logic [11:0] res = '0;
  logic [15:0] data;
  logic        empty, dreq, irq, ovf, unf;
  logic [2:0]  level;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  adc_sample_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .err_mode_i(err_mode),
    .shift_mode_i(shift_mode), .thresh_i(thresh), .dreq_en_i(dreq_en),
    .irq_en_i(irq_en), .push_i(push), .res_i(res), .res_err_i(res_err),
    .pop_i(pop), .ovf_clr_i(ovf_clr), .unf_clr_i(unf_clr), .data_o(data),
    .empty_o(empty), .level_o(level), .dreq_o(dreq), .irq_o(irq),
    .ovf_o(ovf), .unf_o(unf)
  );

  // behavioural reference model
  logic [15:0] q[$];
  bit m_ovf = 0, m_unf = 0;

  function automatic logic [15:0] fmt(input logic [11:0] r, input logic e);
    logic [15:0] w;
    w = shift_mode ? 16'(r >> 4) : 16'(r);
    if (err_mode && e) w[15] = 1'b1;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_unf = 0;
    end else begin
      bit popped, dropped, under;
      popped = 0; dropped = 0; under = 0;
      if (pop) begin
        if (q.size() > 0) begin void'(q.pop_front()); popped = 1; end
        else under = 1;
      end
      if (push && fifo_en) begin
        if (q.size() < 4) q.push_back(fmt(res, res_err));
        else dropped = 1;
      end
      if (dropped) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (under)   m_unf = 1; else if (unf_clr) m_unf = 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  // compare every cycle, 3 ns after the active edge
  always @(posedge clk) begin
    cyc++;
    #3;
    if (rst_n) begin
      int lv;
      lv = q.size();
      chk("data",  data,  (lv > 0) ? q[0] : 0);
      chk("level", level, lv);
      chk("empty", empty, lv == 0);
      chk("dreq",  dreq,  dreq_en && (lv >= thresh));
      chk("irq",   irq,   irq_en && (lv >= thresh));
      chk("ovf",   ovf,   m_ovf);
      chk("unf",   unf,   m_unf);
    end
  end

  task automatic step(input bit ps, input logic [11:0] r, input bit e, input bit pp);
    @(negedge clk);
    push = ps; res = r; res_err = e; pop = pp; ovf_clr = 0; unf_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 12'h0, 0, 0);
  endtask

  initial begin
    #1;
    if (cyc > 20000) ;
  end

  initial begin : watchdog
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    phase = "R1"; idle(3);

    // R2: ordered storage and readout
    phase = "R2"; fifo_en = 1;
    step(1, 12'h123, 0, 0); step(1, 12'hABC, 1, 0); step(1, 12'h5A5, 0, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(1, 12'hFFF, 0, 1); step(0, 0, 0, 1);
    idle(1);

    // R3: drop on full
    phase = "R3";
    for (int i = 0; i < 6; i++) step(1, 12'(12'h100 + i), 0, 0);
    idle(1);

    // R10: write-one clear, set wins over clear
    phase = "R10";
    @(negedge clk); push = 1; res = 12'h777; ovf_clr = 1;
    idle(1);
    @(negedge clk); ovf_clr = 1;
    idle(1);

    // R9: push and pop together on full
    phase = "R9";
    step(1, 12'h9A1, 0, 1); step(1, 12'h9A2, 0, 1); idle(1);

    // R8: underflow
    phase = "R8";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1);
    idle(1);
    phase = "R10";
    @(negedge clk); unf_clr = 1; pop = 1; // set wins
    idle(1);
    @(negedge clk); unf_clr = 1;
    idle(1);

    // R4: disabled FIFO ignores pushes
    phase = "R4"; fifo_en = 0;
    step(1, 12'h444, 0, 0); step(1, 12'h445, 1, 0); idle(1);
    fifo_en = 1;

    // R6: error flag in bit 15
    phase = "R6"; err_mode = 1;
    step(1, 12'h321, 1, 0); step(1, 12'h322, 0, 0);
    err_mode = 0; step(1, 12'h323, 1, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1); idle(1);

    // R7: byte narrowing, fixed at push time
    phase = "R7"; shift_mode = 1;
    step(1, 12'hABC, 0, 0); err_mode = 1; step(1, 12'h5F0, 1, 0);
    shift_mode = 0; err_mode = 0; idle(1);
    step(0, 0, 0, 1); step(0, 0, 0, 1); idle(1);

    // R5: threshold sweep, each enable alone and together
    phase = "R5";
    for (int t = 0; t <= 4; t++) begin
      thresh = 3'(t);
      for (int en = 1; en <= 3; en++) begin
        dreq_en = en[0]; irq_en = en[1];
        for (int i = 0; i < 4; i++) step(1, 12'(t * 16 + i), 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
      end
    end
    dreq_en = 0; irq_en = 0; idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule